// File: doc/BRIEF.md
# Seconds-Count Real-Time Clock with Dual Alarms

This block is a register-mapped real-time clock core. A 32-bit binary seconds counter advances once every `TICK_DIV` pulses of an external 32768 Hz tick enable (`TICK_DIV` defaults to 32768, so one step per second). Software sees eight 32-bit word slots through a small register port: a sticky status word, two per-alarm event configuration words, the time counter, two alarm compare values, a correction-control word and a configuration/test word.

After reset the test word holds a nonzero low byte, which marks the clock as not yet initialised; the counter and its prescaler stand still until software writes zero to that byte. Each alarm owns one status flag. The flag can be raised by a compare match against the counter, or by a repeating frequency event at 1 Hz or at a faster rate set by `PER_DIV`. A single interrupt line reports every flag whose event source is enabled.

Top module: `rtc_sec_core`

## Requirements
- R1: After reset the time counter, both alarm values, both configuration words, the status flags and the correction word read zero, and the test word at slot 7 reads 0x000000FF.
- R2: While bits [7:0] of the test word (slot 7, byte offset 0x1C) are nonzero, the counter and prescaler hold. Writing zero to that byte starts counting.
- R3: While running, the counter at slot 3 (offset 0x0C) increases by one on every `TICK_DIV`-th tick. It wraps from 0xFFFFFFFF to 0.
- R4: A write to slot 3 loads the counter and restarts the prescaler. The next step then comes only after a full `TICK_DIV` ticks, and a tick in the cycle of the write is discarded.
- R5: Status bit k (bit 0 for the alarm at slot 4 / 0x10, bit 1 for the alarm at slot 5 / 0x14) sets on the edge where the counter steps to a value equal to that alarm. Loading the counter or the alarm with an equal value does not set it.
- R6: Status flags at slot 0 (offset 0x0) are sticky. Writing 1 to a bit clears it, and writing 0 leaves it unchanged. If a set and a clear land in the same cycle, the set wins.
- R7: Configuration word k sits at slot 1+k (0x4, 0x8). Bit 0 enables the alarm, bit 1 enables frequency events, and bit 2 selects 1 Hz; only these three bits are stored. With bit 1 set, flag k also sets on every counter step if bit 2 is 1, or on every `PER_DIV`-th tick if bit 2 is 0.
- R8: `irq_o` is high in any cycle where some flag k is set and configuration word k has bit 0 or bit 1 set.
- R9: The correction word at slot 6 (0x18) stores and returns bits [15:0], and the test word stores bits [7:0]. Reads are combinational on `addr_i`, with upper bits zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | One-cycle pulse at the 32768 Hz reference rate |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Word slot (byte offset / 4) |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data of the addressed slot |
| irq_o | output | 1 | Alarm / event interrupt |

## Verification
Read data is valid in the same cycle that `addr_i` changes. A write shows on the following clock edge. A counter step lands on the edge that consumes the `TICK_DIV`-th tick, and the status flag and `irq_o` for that step appear on that same edge. The bench drives inputs one time unit after the rising edge and compares `rdata_o` and `irq_o` with a behavioural model at every falling edge, so each result is checked in the first half-cycle in which it is due. Directed reads add named checks at the reset state, the start gate, the counter wrap and the flag set/clear corners.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int NUM_ALM = 2;
  localparam int TIME_W  = 32;
  localparam int CFG_W   = 3;
  localparam int CORR_W  = 16;
  localparam int TEST_W  = 8;
  localparam int SLOT_W  = 3;

  localparam logic [SLOT_W-1:0] SLOT_STAT = 3'd0;
  localparam logic [SLOT_W-1:0] SLOT_CFG0 = 3'd1;
  localparam logic [SLOT_W-1:0] SLOT_TIME = 3'd3;
  localparam logic [SLOT_W-1:0] SLOT_ALM0 = 3'd4;
  localparam logic [SLOT_W-1:0] SLOT_CORR = 3'd6;
  localparam logic [SLOT_W-1:0] SLOT_TEST = 3'd7;

  localparam int CFG_AL_EN  = 0;
  localparam int CFG_FQ_EN  = 1;
  localparam int CFG_FQ_1HZ = 2;
endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
  parameter int TICK_DIV = 32768,
  parameter int PER_DIV  = 1024
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic tick_i,
  input  logic clr_i,
  output logic sec_o,
  output logic per_o
);
  localparam int CW = $clog2(TICK_DIV + 1);
  localparam int PW = $clog2(PER_DIV + 1);

  logic [CW-1:0] cnt_q;
  logic [PW-1:0] per_q;
  logic step, sec_last, per_last;

  assign step     = run_i & tick_i & ~clr_i;
  assign sec_last = (cnt_q == CW'(TICK_DIV - 1));
  assign per_last = (per_q == PW'(PER_DIV - 1));
  assign sec_o    = step & sec_last;
  assign per_o    = step & per_last;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      per_q <= '0;
    end else if (clr_i) begin
      cnt_q <= '0;
      per_q <= '0;
    end else if (step) begin
      cnt_q <= sec_last ? '0 : cnt_q + 1'b1;
      per_q <= per_last ? '0 : per_q + 1'b1;
    end
  end

  // R4
  restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (cnt_q == '0 && per_q == '0));
  // R2
  frozen_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i && !clr_i) |=> $stable(cnt_q));
endmodule

// File: rtl/rtc_alarm_unit.sv
module rtc_alarm_unit
  import rtc_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sec_i,
  input  logic              per_i,
  input  logic [TIME_W-1:0] next_time_i,
  input  logic              alm_wr_i,
  input  logic              cfg_wr_i,
  input  logic              clr_i,
  input  logic [TIME_W-1:0] wdata_i,
  output logic [TIME_W-1:0] alm_o,
  output logic [CFG_W-1:0]  cfg_o,
  output logic              flag_o,
  output logic              irq_o
);
  logic [TIME_W-1:0] alm_q;
  logic [CFG_W-1:0]  cfg_q;
  logic              flag_q;
  logic              match, freq_ev, set;

  assign match   = sec_i && (next_time_i == alm_q);
  assign freq_ev = cfg_q[CFG_FQ_EN] && (cfg_q[CFG_FQ_1HZ] ? sec_i : per_i);
  assign set     = match | freq_ev;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      alm_q  <= '0;
      cfg_q  <= '0;
      flag_q <= 1'b0;
    end else begin
      if (alm_wr_i) alm_q <= wdata_i;
      if (cfg_wr_i) cfg_q <= wdata_i[CFG_W-1:0];
      flag_q <= set | (flag_q & ~clr_i);  // set wins over ack
    end
  end

  assign alm_o  = alm_q;
  assign cfg_o  = cfg_q;
  assign flag_o = flag_q;
  assign irq_o  = flag_q & (cfg_q[CFG_AL_EN] | cfg_q[CFG_FQ_EN]);

  // R6
  flag_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_q && !clr_i) |=> flag_q);
  // R5
  flag_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!flag_q && !sec_i && !per_i) |=> !flag_q);
endmodule

// File: rtl/rtc_sec_core.sv
module rtc_sec_core
  import rtc_pkg::*;
#(
  parameter int          TICK_DIV = 32768,
  parameter int          PER_DIV  = 1024,
  parameter logic [7:0]  TEST_RST = 8'hFF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              wr_en_i,
  input  logic [SLOT_W-1:0] addr_i,
  input  logic [TIME_W-1:0] wdata_i,
  output logic [TIME_W-1:0] rdata_o,
  output logic              irq_o
);
  logic [TIME_W-1:0] time_q, next_time;
  logic [CORR_W-1:0] corr_q;
  logic [TEST_W-1:0] test_q;
  logic              run, wr_time, sec, per;
  logic [NUM_ALM-1:0]             flag_vec, irq_vec;
  logic [NUM_ALM-1:0][TIME_W-1:0] alm_vec;
  logic [NUM_ALM-1:0][CFG_W-1:0]  cfg_vec;

  assign run       = (test_q == '0);
  assign wr_time   = wr_en_i && (addr_i == SLOT_TIME);
  assign next_time = time_q + 1'b1;

  rtc_prescaler #(.TICK_DIV(TICK_DIV), .PER_DIV(PER_DIV)) u_presc (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .run_i (run),
    .tick_i(tick_i),
    .clr_i (wr_time),
    .sec_o (sec),
    .per_o (per)
  );

  for (genvar k = 0; k < NUM_ALM; k++) begin : g_alm
    rtc_alarm_unit u_alm (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .sec_i      (sec),
      .per_i      (per),
      .next_time_i(next_time),
      .alm_wr_i   (wr_en_i && (addr_i == SLOT_W'(SLOT_ALM0 + k))),
      .cfg_wr_i   (wr_en_i && (addr_i == SLOT_W'(SLOT_CFG0 + k))),
      .clr_i      (wr_en_i && (addr_i == SLOT_STAT) && wdata_i[k]),
      .wdata_i    (wdata_i),
      .alm_o      (alm_vec[k]),
      .cfg_o      (cfg_vec[k]),
      .flag_o     (flag_vec[k]),
      .irq_o      (irq_vec[k])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      time_q <= '0;
      corr_q <= '0;
      test_q <= TEST_RST;
    end else begin
      if (wr_time)  time_q <= wdata_i;
      else if (sec) time_q <= next_time;
      if (wr_en_i && addr_i == SLOT_CORR) corr_q <= wdata_i[CORR_W-1:0];
      if (wr_en_i && addr_i == SLOT_TEST) test_q <= wdata_i[TEST_W-1:0];
    end
  end

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      SLOT_STAT: rdata_o[NUM_ALM-1:0] = flag_vec;
      3'd1:      rdata_o[CFG_W-1:0]   = cfg_vec[0];
      3'd2:      rdata_o[CFG_W-1:0]   = cfg_vec[1];
      SLOT_TIME: rdata_o              = time_q;
      3'd4:      rdata_o              = alm_vec[0];
      3'd5:      rdata_o              = alm_vec[1];
      SLOT_CORR: rdata_o[CORR_W-1:0]  = corr_q;
      SLOT_TEST: rdata_o[TEST_W-1:0]  = test_q;
      default:   rdata_o              = '0;
    endcase
  end

  assign irq_o = |irq_vec;

  // R3
  time_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sec && !wr_time) |=> time_q == $past(time_q) + 32'd1);
  // R2
  time_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run && !wr_time) |=> $stable(time_q));
  // R8
  irq_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (flag_vec != '0));
endmodule

// File: tb/rtc_sec_core_test.sv
module rtc_sec_core_test;
  localparam int CLK_PERIOD = 10;
  localparam int TD = 4;
  localparam int PD = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  addr = 3'd0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;

  int checks = 0;
  int errors = 0;
  bit tick_on = 1'b0;
  int cyc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rtc_sec_core #(.TICK_DIV(TD), .PER_DIV(PD)) uut (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .wr_en_i(wr_en),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  // behavioural reference
  bit [31:0] m_time;
  bit [31:0] m_al [2];
  bit [2:0]  m_cfg [2];
  bit [1:0]  m_flag;
  bit [15:0] m_corr;
  bit [7:0]  m_test;
  int        m_pre, m_per;

  function automatic bit [31:0] mread(bit [2:0] a);
    case (a)
      3'd0: return {30'b0, m_flag};
      3'd1: return {29'b0, m_cfg[0]};
      3'd2: return {29'b0, m_cfg[1]};
      3'd3: return m_time;
      3'd4: return m_al[0];
      3'd5: return m_al[1];
      3'd6: return {16'b0, m_corr};
      default: return {24'b0, m_test};
    endcase
  endfunction

  function automatic string tag(bit [2:0] a);
    case (a)
      3'd0: return "R6";
      3'd1, 3'd2: return "R7";
      3'd3: return "R3";
      3'd4, 3'd5: return "R5";
      default: return "R9";
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin : model
    bit sec, perv, twr;
    bit [31:0] nt;
    bit [1:0] set, clr;
    if (!rst_n) begin
      m_time = 0; m_al[0] = 0; m_al[1] = 0; m_cfg[0] = 0; m_cfg[1] = 0;
      m_flag = 0; m_corr = 0; m_test = 8'hFF; m_pre = 0; m_per = 0;
    end else begin
      sec = 0; perv = 0;
      twr = wr_en && addr == 3'd3;
      if (m_test == 0 && tick && !twr) begin
        if (m_pre == TD - 1) begin m_pre = 0; sec = 1; end else m_pre++;
        if (m_per == PD - 1) begin m_per = 0; perv = 1; end else m_per++;
      end
      nt = m_time + 1;
      for (int k = 0; k < 2; k++)
        set[k] = (sec && nt == m_al[k]) || (m_cfg[k][1] && (m_cfg[k][2] ? sec : perv));
      clr = (wr_en && addr == 3'd0) ? wdata[1:0] : 2'b00;
      m_flag = (m_flag & ~clr) | set;
      if (sec) m_time = nt;
      if (wr_en) begin
        case (addr)
          3'd1: m_cfg[0] = wdata[2:0];
          3'd2: m_cfg[1] = wdata[2:0];
          3'd3: begin m_time = wdata; m_pre = 0; m_per = 0; end
          3'd4: m_al[0] = wdata;
          3'd5: m_al[1] = wdata;
          3'd6: m_corr = wdata[15:0];
          3'd7: m_test = wdata[7:0];
          default: ;
        endcase
      end
    end
  end

  // tick every second cycle
  always @(posedge clk) begin
    cyc <= cyc + 1;
    #1 tick = tick_on && (cyc % 2 == 0);
  end

  // per-cycle comparison
  always @(negedge clk) begin
    if (rst_n) begin
      bit exp_irq;
      exp_irq = (m_flag[0] && (m_cfg[0][0] || m_cfg[0][1])) ||
                (m_flag[1] && (m_cfg[1][0] || m_cfg[1][1]));
      checks++;
      if (irq !== exp_irq) begin
        errors++;
        $display("FAIL R8 irq_o got %0b expected %0b at cycle %0d", irq, exp_irq, cyc);
      end
      checks++;
      if (rdata !== mread(addr)) begin
        errors++;
        $display("FAIL %s slot %0d read got %h expected %h", tag(addr), addr, rdata, mread(addr));
      end
    end
  end

  task automatic chk(string name, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h", name, got, exp);
    end
  endtask

  task automatic wr(bit [2:0] a, bit [31:0] d);
    @(posedge clk); #1;
    wr_en = 1'b1; addr = a; wdata = d;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic rd(bit [2:0] a, output logic [31:0] d);
    @(posedge clk); #1;
    addr = a;
    @(negedge clk);
    d = rdata;
  endtask

  task automatic idle(int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin : stim
    logic [31:0] v, t0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    rd(3'd7, v); chk("R1 test reset", v, 32'hFF);
    rd(3'd3, v); chk("R1 time reset", v, 32'h0);
    rd(3'd0, v); chk("R1 status reset", v, 32'h0);
    rd(3'd1, v); chk("R1 cfg reset", v, 32'h0);
    tick_on = 1'b1;
    idle(30);
    rd(3'd3, v); chk("R2 held while uninitialised", v, 32'h0);
    wr(3'd7, 32'h0);
    idle(40);
    rd(3'd3, v); chk("R2 counting after start", {31'b0, v != 0}, 32'h1);
    // alarm 0 at time+2
    rd(3'd3, t0);
    wr(3'd1, 32'h1);
    wr(3'd4, t0 + 2);
    idle(40);
    rd(3'd0, v); chk("R5 alarm0 flag", v & 32'h1, 32'h1);
    chk("R8 irq from alarm0", {31'b0, irq}, 32'h1);
    wr(3'd0, 32'h0);
    rd(3'd0, v); chk("R6 write zero keeps flag", v & 32'h1, 32'h1);
    wr(3'd0, 32'h1);
    rd(3'd0, v); chk("R6 write one clears", v & 32'h1, 32'h0);
    chk("R8 irq low after ack", {31'b0, irq}, 32'h0);
    // equal-value loads do not set
    rd(3'd3, t0);
    wr(3'd5, t0);
    rd(3'd0, v); chk("R5 equal alarm load no set", v & 32'h2, 32'h0);
    // 1 Hz frequency event on alarm 1
    wr(3'd2, 32'h6);
    idle(12);
    rd(3'd0, v); chk("R7 1Hz event flag1", v & 32'h2, 32'h2);
    wr(3'd0, 32'h2);
    wr(3'd2, 32'h2);
    idle(6);
    rd(3'd0, v); chk("R7 periodic event flag1", v & 32'h2, 32'h2);
    wr(3'd2, 32'hFFFF_FFF8);
    rd(3'd2, v); chk("R7 cfg only 3 bits", v, 32'h0);
    wr(3'd0, 32'h3);
    rd(3'd0, v); chk("R6 both flags cleared", v, 32'h0);
    wr(3'd6, 32'h1234_5678);
    rd(3'd6, v); chk("R9 correction low 16 bits", v, 32'h5678);
    // load and restart
    wr(3'd3, 32'd100);
    rd(3'd3, v); chk("R4 time load", v, 32'd100);
    // wrap
    wr(3'd3, 32'hFFFF_FFFE);
    idle(24);
    rd(3'd3, v); chk("R3 counter wrapped", {31'b0, v < 32'd4}, 32'h1);
    // stop again
    wr(3'd7, 32'hABCD_0005);
    rd(3'd7, v); chk("R9 test low 8 bits", v, 32'h5);
    rd(3'd3, t0);
    idle(30);
    rd(3'd3, v); chk("R2 stopped by nonzero test", v, t0);
    idle(4);
    finish_run();
  end
endmodule